// File: doc/BRIEF.md
# Counter-Hypothesis Candidate Adder

This block runs at one level of a breadth-first soft-output tree search. It adds competing paths to a side list, so that every bit at that level has a path that carries the opposite value. When a new list of partial paths arrives, a comparator tree picks the valid path with the smallest accumulated metric. The block reports that path to an external best-child selector. The selector returns the best child label of that path together with per-label tables of the channel, a-priori and self-interference terms. The block then flips each bit of the child label in turn. It streams the three resulting siblings one per cycle through a single metric unit, and each record carries its new accumulated metric.

A complete vector takes one cycle for the start, one cycle for the child and three cycles of records. The next start can overlap the last record, so the block keeps a rate of one vector every four cycles. Levels above the first level that is allowed to add siblings produce no selection and no records.

Top module: `cand_flip_adder`

## Requirements
- R1: One cycle after `start`, `sel_idx` and `sel_metric` name the valid list entry with the smallest metric. When several entries tie, the one with the lowest index is chosen.
- R2: Entries whose `path_valid` bit is 0 are never selected. If no entry is valid, `sel_valid` stays 0 and no records follow.
- R3: `sel_valid` pulses one cycle after `start` only when `level` is at least FIRST_LEVEL (default 2, counted from 0 at the top). A `start` at a lower level produces nothing.
- R4: A child that is accepted at clock edge E produces records at edges E+1, E+2 and E+3. Their `out_flip` values are 0, 1 and 2 in that order, and each `out_label` is the child label XOR (1 << `out_flip`).
- R5: `out_metric` is parent metric + channel term + a-priori term − self-interference term. Each term is taken at the sibling label, entry L occupying bits [L*TW +: TW] of its table. The result is a two's-complement number of MW+2 bits.
- R6: Every record carries the level and the list index of the selected parent.
- R7: `child_valid` is accepted only when a selection is pending and no emission is in progress. Each selection accepts at most one child, and any other `child_valid` has no effect.
- R8: The term tables and the parent are captured when the child is accepted. Changes to them during the emission do not alter the records.
- R9: While `rst` is high, `sel_valid` and `out_valid` are 0 at the next edge.
- R10: An accepted selection produces exactly three records, never more than one per cycle, and a new vector can start every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New path list present |
| level | input | LVW | Tree level of this list, 0 at the top |
| path_valid | input | NUM_PATHS | Valid flag of each list entry |
| path_metric | input | NUM_PATHS*MW | Accumulated metric of each entry, entry k at [k*MW +: MW] |
| sel_valid | output | 1 | Selection pulse to the best-child selector |
| sel_idx | output | IW | Index of the minimum-metric path |
| sel_metric | output | MW | Metric of that path |
| child_valid | input | 1 | Best child and term tables present |
| child_label | input | LBITS | Best child label of the selected path |
| ch_terms | input | NLAB*TW | Channel term per label |
| ap_terms | input | NLAB*TW | A-priori term per label |
| si_terms | input | NLAB*TW | Self-interference term per label |
| out_valid | output | 1 | Added candidate record valid |
| out_level | output | LVW | Level tag of the record |
| out_parent | output | IW | List index of the parent path |
| out_label | output | LBITS | Sibling label at this level |
| out_flip | output | FW | Bit that was flipped |
| out_metric | output | MW+2 | Updated accumulated metric, signed |

## Verification
If the comparator tree broke a tie or handled an invalid entry wrongly, `sel_idx` would differ from the reference on the cycle right after `start`. If the pending-selection or busy state were wrong, a missing, extra or fourth record would appear within five cycles of the child. If the sequencer counted wrongly or the term mux were wrong, the flip order, the label or the metric would be off on the very record concerned. Changes to the tables in the middle of an emission, and children held high or sent with no selection pending, expose state that was captured at the wrong time.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  localparam int DEF_PATHS = 32;
  localparam int DEF_MW    = 16;
  localparam int DEF_TW    = 12;
  localparam int DEF_LBITS = 3;
  localparam int DEF_LVW   = 3;
  localparam int DEF_FIRST = 2;

  // width of a bit-position counter for a label of lbits bits
  function automatic int flip_width(input int lbits);
    return (lbits < 2) ? 1 : $clog2(lbits);
  endfunction
endpackage

// File: rtl/cfa_min_tree.sv
module cfa_min_tree #(
  parameter int N  = 32,
  parameter int MW = 16,
  parameter int IW = 5
) (
  input  logic [N-1:0]    in_valid,
  input  logic [N*MW-1:0] in_metric,
  output logic            out_any,
  output logic [IW-1:0]   out_idx,
  output logic [MW-1:0]   out_metric
);
  localparam int LG = (N < 2) ? 1 : $clog2(N);
  localparam int P2 = 1 << LG;

  for (genvar lv = 0; lv <= LG; lv++) begin : g_lv
    localparam int W = P2 >> lv;
    logic          v  [W];
    logic [MW-1:0] m  [W];
    logic [IW-1:0] ix [W];
    if (lv == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < N) begin : g_real
          assign v[k]  = in_valid[k];
          assign m[k]  = in_metric[k*MW +: MW];
          assign ix[k] = IW'(k);
        end else begin : g_pad
          assign v[k]  = 1'b0;
          assign m[k]  = '1;
          assign ix[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        logic take_left;
        // lower index wins on equal metric
        assign take_left = g_lv[lv-1].v[2*k] &
                           (~g_lv[lv-1].v[2*k+1] |
                            (g_lv[lv-1].m[2*k] <= g_lv[lv-1].m[2*k+1]));
        assign v[k]  = g_lv[lv-1].v[2*k] | g_lv[lv-1].v[2*k+1];
        assign m[k]  = take_left ? g_lv[lv-1].m[2*k]  : g_lv[lv-1].m[2*k+1];
        assign ix[k] = take_left ? g_lv[lv-1].ix[2*k] : g_lv[lv-1].ix[2*k+1];
      end
    end
  end

  assign out_any    = g_lv[LG].v[0];
  assign out_idx    = g_lv[LG].ix[0];
  assign out_metric = g_lv[LG].m[0];
endmodule

// File: rtl/cfa_flip_seq.sv
module cfa_flip_seq #(
  parameter int LBITS = 3,
  parameter int FW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [LBITS-1:0] child_label,
  output logic             busy,
  output logic [FW-1:0]    cur_flip,
  output logic [LBITS-1:0] cur_label
);
  logic [FW-1:0]    cnt_q;
  logic [LBITS-1:0] lab_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == FW'(LBITS-1)) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) lab_q <= child_label;
  end

  assign busy      = busy_q;
  assign cur_flip  = cnt_q;
  assign cur_label = lab_q ^ (LBITS'(1) << cnt_q);
endmodule

// File: rtl/cfa_metric_unit.sv
module cfa_metric_unit #(
  parameter int MW    = 16,
  parameter int TW    = 12,
  parameter int OW    = 18,
  parameter int LVW   = 3,
  parameter int IW    = 5,
  parameter int LBITS = 3,
  parameter int FW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MW-1:0]    parent_metric,
  input  logic [TW-1:0]    ch_term,
  input  logic [TW-1:0]    ap_term,
  input  logic [TW-1:0]    si_term,
  input  logic [LVW-1:0]   in_level,
  input  logic [IW-1:0]    in_parent,
  input  logic [LBITS-1:0] in_label,
  input  logic [FW-1:0]    in_flip,
  output logic             out_valid,
  output logic [LVW-1:0]   out_level,
  output logic [IW-1:0]    out_parent,
  output logic [LBITS-1:0] out_label,
  output logic [FW-1:0]    out_flip,
  output logic [OW-1:0]    out_metric
);
  logic [OW-1:0] sum;
  assign sum = OW'(parent_metric) + OW'(ch_term) + OW'(ap_term) - OW'(si_term);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_metric <= sum;
      out_level  <= in_level;
      out_parent <= in_parent;
      out_label  <= in_label;
      out_flip   <= in_flip;
    end
  end
endmodule

// File: rtl/cand_flip_adder.sv
module cand_flip_adder #(
  parameter int NUM_PATHS   = cfa_pkg::DEF_PATHS,
  parameter int MW          = cfa_pkg::DEF_MW,
  parameter int TW          = cfa_pkg::DEF_TW,
  parameter int LBITS       = cfa_pkg::DEF_LBITS,
  parameter int LVW         = cfa_pkg::DEF_LVW,
  parameter int FIRST_LEVEL = cfa_pkg::DEF_FIRST,
  localparam int IW   = (NUM_PATHS < 2) ? 1 : $clog2(NUM_PATHS),
  localparam int FW   = cfa_pkg::flip_width(LBITS),
  localparam int NLAB = 1 << LBITS,
  localparam int OW   = MW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [LVW-1:0]       level,
  input  logic [NUM_PATHS-1:0] path_valid,
  input  logic [NUM_PATHS*MW-1:0] path_metric,
  output logic                 sel_valid,
  output logic [IW-1:0]        sel_idx,
  output logic [MW-1:0]        sel_metric,
  input  logic                 child_valid,
  input  logic [LBITS-1:0]     child_label,
  input  logic [NLAB*TW-1:0]   ch_terms,
  input  logic [NLAB*TW-1:0]   ap_terms,
  input  logic [NLAB*TW-1:0]   si_terms,
  output logic                 out_valid,
  output logic [LVW-1:0]       out_level,
  output logic [IW-1:0]        out_parent,
  output logic [LBITS-1:0]     out_label,
  output logic [FW-1:0]        out_flip,
  output logic [OW-1:0]        out_metric
);
  logic          min_any;
  logic [IW-1:0] min_idx;
  logic [MW-1:0] min_metric;

  cfa_min_tree #(.N(NUM_PATHS), .MW(MW), .IW(IW)) u_min (
    .in_valid  (path_valid),
    .in_metric (path_metric),
    .out_any   (min_any),
    .out_idx   (min_idx),
    .out_metric(min_metric)
  );

  logic sel_ok;
  assign sel_ok = min_any & (level >= LVW'(FIRST_LEVEL));

  // selection hold and pending flag
  logic           sel_valid_q, armed_q;
  logic [IW-1:0]  sel_idx_q;
  logic [MW-1:0]  sel_metric_q;
  logic [LVW-1:0] sel_level_q;
  logic           busy, accept;

  assign accept = child_valid & armed_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      sel_valid_q <= start & sel_ok;
      if (start)       armed_q <= sel_ok;
      else if (accept) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      sel_idx_q    <= min_idx;
      sel_metric_q <= min_metric;
      sel_level_q  <= level;
    end
  end

  // context captured at child acceptance
  logic [IW-1:0]      e_idx;
  logic [MW-1:0]      e_metric;
  logic [LVW-1:0]     e_level;
  logic [NLAB*TW-1:0] e_ch, e_ap, e_si;

  always_ff @(posedge clk) begin
    if (accept) begin
      e_idx    <= sel_idx_q;
      e_metric <= sel_metric_q;
      e_level  <= sel_level_q;
      e_ch     <= ch_terms;
      e_ap     <= ap_terms;
      e_si     <= si_terms;
    end
  end

  logic [FW-1:0]    cur_flip;
  logic [LBITS-1:0] cur_label;

  cfa_flip_seq #(.LBITS(LBITS), .FW(FW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .child_label(child_label),
    .busy       (busy),
    .cur_flip   (cur_flip),
    .cur_label  (cur_label)
  );

  cfa_metric_unit #(
    .MW(MW), .TW(TW), .OW(OW), .LVW(LVW), .IW(IW), .LBITS(LBITS), .FW(FW)
  ) u_met (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (busy),
    .parent_metric(e_metric),
    .ch_term      (e_ch[cur_label*TW +: TW]),
    .ap_term      (e_ap[cur_label*TW +: TW]),
    .si_term      (e_si[cur_label*TW +: TW]),
    .in_level     (e_level),
    .in_parent    (e_idx),
    .in_label     (cur_label),
    .in_flip      (cur_flip),
    .out_valid    (out_valid),
    .out_level    (out_level),
    .out_parent   (out_parent),
    .out_label    (out_label),
    .out_flip     (out_flip),
    .out_metric   (out_metric)
  );

  assign sel_valid  = sel_valid_q;
  assign sel_idx    = sel_idx_q;
  assign sel_metric = sel_metric_q;
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
  parameter int NUM_PATHS   = 32,
  parameter int LBITS       = 3,
  parameter int LVW         = 3,
  parameter int FIRST_LEVEL = 2,
  parameter int IW          = 5,
  parameter int FW          = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [LVW-1:0]       level,
  input logic [NUM_PATHS-1:0] path_valid,
  input logic                 sel_valid,
  input logic [IW-1:0]        sel_idx,
  input logic                 out_valid,
  input logic [FW-1:0]        out_flip,
  input logic [LBITS-1:0]     out_label,
  input logic [IW-1:0]        out_parent,
  input logic [LVW-1:0]       out_level
);
  logic                 start_q;
  logic [LVW-1:0]       level_q;
  logic [NUM_PATHS-1:0] pv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      level_q <= '0;
      pv_q    <= '0;
    end else begin
      start_q <= start;
      level_q <= level;
      pv_q    <= path_valid;
    end
  end

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !sel_valid));

  a_r3_level_gate: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (start_q && level_q >= LVW'(FIRST_LEVEL)));

  a_r2_valid_pick: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> pv_q[sel_idx]);

  a_r4_first_flip: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_flip == '0));

  a_r4_flip_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flip != FW'(LBITS-1)) |=>
      (out_valid && out_flip == $past(out_flip) + 1'b1));

  a_r4_sibling_pair: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flip != '0) |-> ($countones(out_label ^ $past(out_label)) == 2));

  a_r6_context_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flip != '0) |-> ($stable(out_parent) && $stable(out_level)));
endmodule

bind cand_flip_adder cfa_checker #(
  .NUM_PATHS(NUM_PATHS), .LBITS(LBITS), .LVW(LVW),
  .FIRST_LEVEL(FIRST_LEVEL), .IW(IW), .FW(FW)
) u_chk (.*);

// File: tb/cand_flip_adder_test.sv
module cand_flip_adder_test;
  localparam int NP = 32, MW = 16, TW = 12, LB = 3, LVW = 3;
  localparam int NL = 8, IW = 5, FW = 2, OW = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, child_valid;
  logic [LVW-1:0] level;
  logic [NP-1:0] path_valid;
  logic [NP*MW-1:0] path_metric;
  logic [LB-1:0] child_label;
  logic [NL*TW-1:0] ch_terms, ap_terms, si_terms;
  logic sel_valid, out_valid;
  logic [IW-1:0] sel_idx, out_parent;
  logic [MW-1:0] sel_metric;
  logic [LVW-1:0] out_level;
  logic [LB-1:0] out_label;
  logic [FW-1:0] out_flip;
  logic [OW-1:0] out_metric;

  cand_flip_adder uut (.*);

  int pv[NP], pm[NP], chv[NL], apv[NL], siv[NL];
  int checks = 0, failures = 0, cyc = 0, recs = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pack();
    for (int k = 0; k < NP; k++) begin
      path_valid[k] = pv[k][0];
      path_metric[k*MW +: MW] = pm[k][MW-1:0];
    end
    for (int k = 0; k < NL; k++) begin
      ch_terms[k*TW +: TW] = chv[k][TW-1:0];
      ap_terms[k*TW +: TW] = apv[k][TW-1:0];
      si_terms[k*TW +: TW] = siv[k][TW-1:0];
    end
  endtask

  task automatic rnd_list(int tie);
    for (int k = 0; k < NP; k++) begin
      pv[k] = ($urandom % 4) != 0;
      pm[k] = $urandom % 65536;
    end
    if (tie != 0) begin
      pm[5] = 3; pm[9] = 3; pm[20] = 3; pv[9] = 1; pv[20] = 1;
    end
    for (int k = 0; k < NL; k++) begin
      chv[k] = $urandom % 4096; apv[k] = $urandom % 4096; siv[k] = $urandom % 4096;
    end
  endtask

  // reference model state
  int m_armed, m_busy, m_cnt, h_idx, h_m, h_lv;
  int e_idx, e_m, e_lv, e_lab, e_ch[NL], e_ap[NL], e_si[NL];
  int x_sv, x_si, x_sm, x_ov, x_fl, x_lab, x_met, x_par, x_lv;
  bit m_rst;

  always @(posedge clk) begin
    int busy_old, armed_old, acc, best, ok;
    cyc++;
    m_rst = rst;
    if (rst) begin
      m_armed = 0; m_busy = 0; m_cnt = 0; x_sv = 0; x_ov = 0;
    end else begin
      busy_old = m_busy; armed_old = m_armed;
      x_ov = 0;
      if (m_busy != 0) begin
        x_ov = 1; x_fl = m_cnt; x_lab = e_lab ^ (1 << m_cnt);
        x_met = e_m + e_ch[x_lab] + e_ap[x_lab] - e_si[x_lab];
        x_par = e_idx; x_lv = e_lv;
        m_cnt++;
        if (m_cnt == 3) m_busy = 0;
      end
      acc = (child_valid && armed_old != 0 && busy_old == 0);
      if (acc != 0) begin
        e_idx = h_idx; e_m = h_m; e_lv = h_lv; e_lab = child_label;
        for (int k = 0; k < NL; k++) begin
          e_ch[k] = chv[k]; e_ap[k] = apv[k]; e_si[k] = siv[k];
        end
        m_busy = 1; m_cnt = 0;
      end
      x_sv = 0;
      if (start) begin
        best = -1;
        for (int k = 0; k < NP; k++)
          if (pv[k] != 0 && (best < 0 || pm[k] < pm[best])) best = k;
        ok = (best >= 0 && level >= 2);
        x_sv = ok;
        if (ok != 0) begin h_idx = best; h_m = pm[best]; h_lv = level; end
        m_armed = ok;
      end else if (acc != 0) m_armed = 0;
    end
    #1;
    if (!done) begin
      chk(m_rst ? "R9 sel_valid" : "R2_R3 sel_valid", sel_valid, x_sv);
      chk(m_rst ? "R9 out_valid" : "R7 out_valid", out_valid, x_ov);
      if (x_sv != 0) begin
        chk("R1 sel_idx", sel_idx, x_si_f());
        chk("R1 sel_metric", sel_metric, h_m);
      end
      if (x_ov != 0 && out_valid) begin
        recs++;
        chk("R4 out_flip", out_flip, x_fl);
        chk("R4 out_label", out_label, x_lab);
        chk("R5_R8 out_metric", int'($signed(out_metric)), x_met);
        chk("R6 out_parent", out_parent, x_par);
        chk("R6 out_level", out_level, x_lv);
      end
    end
  end

  function automatic int x_si_f();
    return h_idx;
  endfunction

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic vec(int lv, int lab, int gap);
    level = lv[LVW-1:0]; start = 1; pack();
    @(negedge clk);
    start = 0; child_valid = 1; child_label = lab[LB-1:0];
    @(negedge clk);
    child_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    int r0, okv;
    rst = 1; start = 0; child_valid = 0; level = '0; child_label = '0;
    for (int k = 0; k < NP; k++) begin pv[k] = 0; pm[k] = 0; end
    for (int k = 0; k < NL; k++) begin chv[k] = 0; apv[k] = 0; siv[k] = 0; end
    pack();
    repeat (3) @(negedge clk);
    rst = 0;
    // R7: child with no selection pending
    child_valid = 1; child_label = 3'd5; @(negedge clk); child_valid = 0;
    @(negedge clk);
    // R1: tie at metric 3, lowest index wins; invalid smaller entry at 2 (R2)
    rnd_list(1); pv[5] = 1; pm[2] = 0; pv[2] = 0;
    vec(3, 6, 4);
    // R1: minimum at the last and first index
    rnd_list(0); pv[31] = 1; pm[31] = 1; vec(2, 1, 4);
    rnd_list(0); pv[0] = 1; pm[0] = 0; vec(7, 7, 4);
    // R2: all invalid
    rnd_list(0); for (int k = 0; k < NP; k++) pv[k] = 0; vec(4, 2, 4);
    // R3: level below the first adding level
    rnd_list(0); vec(1, 3, 4); rnd_list(0); vec(0, 3, 4);
    // R5: negative result
    rnd_list(0); for (int k = 0; k < NP; k++) begin pv[k] = 1; pm[k] = 10 + k; end
    for (int k = 0; k < NL; k++) begin chv[k] = 0; apv[k] = 0; siv[k] = 4095; end
    vec(2, 0, 4);
    // R7: child held high through busy and after acceptance
    rnd_list(0); pv[3] = 1; level = 3'd5; start = 1; pack();
    @(negedge clk); start = 0; child_valid = 1; child_label = 3'd4;
    repeat (5) @(negedge clk); child_valid = 0; @(negedge clk);
    // R8: tables change during emission
    rnd_list(0); pv[1] = 1; level = 3'd2; start = 1; pack();
    @(negedge clk); start = 0; child_valid = 1; child_label = 3'd2;
    @(negedge clk); child_valid = 0;
    for (int k = 0; k < NL; k++) begin chv[k] = 4095 - k; apv[k] = k; siv[k] = 7; end
    pack(); repeat (4) @(negedge clk);
    // R10: back-to-back at four cycles per vector
    r0 = recs;
    for (int v = 0; v < 6; v++) begin
      rnd_list(0); pv[v] = 1; vec(2 + v % 5, v, 2);
    end
    repeat (4) @(negedge clk);
    chk("R10 back-to-back records", recs - r0, 18);
    // R10: random vectors, three records per accepted selection
    for (int v = 0; v < 150; v++) begin
      rnd_list(v % 7 == 0);
      okv = 0;
      for (int k = 0; k < NP; k++) if (pv[k] != 0) okv = 1;
      r0 = recs;
      level = 3'($urandom % 8);
      if (level < 2) okv = 0;
      vec(level, $urandom % 8, 3);
      chk("R10 records per vector", recs - r0, okv * 3);
    end
    // R9: reset in the middle of an emission
    rnd_list(0); pv[8] = 1; level = 3'd3; start = 1; pack();
    @(negedge clk); start = 0; child_valid = 1; child_label = 3'd1;
    @(negedge clk); child_valid = 0; rst = 1;
    repeat (2) @(negedge clk); rst = 0; repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule